// File: doc/BRIEF.md
# Dual-Channel Mark/Space PWM Generator

This block drives two PWM outputs. Each output is set by a pair of counts: a mark count (how many prescaled ticks the output stays high) and a space count (how many prescaled ticks it stays low). Each channel picks one of four clock-enable tick inputs. It then divides that tick stream through its own 7-bit prescaler, and a gate bit decides whether the divided ticks reach the channel's sequencer. Software programs the block through a small word-addressed register bus. There is one count word per channel and one control word shared by both channels.

Each channel runs a four-state sequencer. IDLE holds the output low while the channel is disabled. HIGH counts down the mark, LOW counts down the space, and ZERO holds the output low when both counts are zero. The transitions are as follows. Enable moves the sequencer from IDLE to a period start. A tick that ends the mark moves HIGH to LOW, or to a period start when the space is zero. A tick that ends the space moves LOW to a period start. Any tick in ZERO goes to a period start. A period start enters HIGH when the mark is nonzero, LOW when only the space is nonzero, and ZERO otherwise. Clearing the enable sends every state to IDLE. A count word written while a period runs is taken only at the next period start.

Top module: `pwm_pair`

## Requirements
- R1: After reset, every register reads zero and both outputs are low.
- R2: Count words sit at byte offsets 0x0 (channel A) and 0x4 (channel B) and hold all 32 written bits. The control word sits at 0x8 and keeps only bits 23:4 and 1:0, so a write reads back ANDed with 0x00FFFFF3. Offset 0xC and any address with bits 1:0 nonzero read zero, and writes to them change nothing.
- R3: In a count word, bits 31:16 are the mark and bits 15:0 the space. The output is high for mark prescaled ticks, then low for space prescaled ticks, and repeats.
- R4: The prescaler field sits at control bits 14:8 for A and 22:16 for B. A value N gives one prescaled tick per N+1 selected source ticks.
- R5: The source select sits at control bits 5:4 for A and 7:6 for B. Value k picks tick input k.
- R6: The gate sits at control bit 15 for A and bit 23 for B. While the gate is clear, no prescaled tick arrives and the output keeps its level.
- R7: A zero mark with a nonzero space gives a constant low output. A zero space with a nonzero mark gives a constant high output.
- R8: With both counts zero, the output is held low.
- R9: A new count word takes effect only at the next period start, so the period already running completes with its old counts.
- R10: Enable is control bit 0 for A and bit 1 for B. A disabled channel drives low and drops its phase. One clock after enable, a channel with a nonzero mark goes high and runs a full mark.
- R11: The channels are independent: channel B, using its own fields, runs while channel A stays disabled and low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Write strobe |
| bus_addr | input | 4 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| tick_src | input | 4 | Four clock-enable tick sources |
| pwm_o | output | 2 | Bit 0 is channel A, bit 1 is channel B |

## Verification
A sequencer stuck in the wrong state, or a countdown that is off by one, changes the length of the high and low runs at the output within a single period. The runs are therefore measured in clocks against mark and space times the divide ratio for each source. A wrong reload point only shows in the period that is running when the count word changes, so one check rewrites the word partway through a mark and times that mark and the next one. A gate, select or enable decoded from the wrong bit shows within one clock as an output that starts, freezes or fails to rise.

// File: rtl/pwm_pair_pkg.sv
package pwm_pair_pkg;
    localparam int WORD_W     = 32;
    localparam int CNT_W      = 16;
    localparam int DIV_W      = 7;
    localparam int SEL_W      = 2;
    localparam int NUM_CH     = 2;
    localparam int NUM_SRC    = 1 << SEL_W;
    // field placement inside the words (decoded by software, so fixed)
    localparam int MARK_LSB   = 16;
    localparam int EN_LSB     = 0;
    localparam int SEL_LSB    = 4;
    localparam int SEL_STRIDE = 2;
    localparam int DIV_LSB    = 8;
    localparam int GATE_LSB   = 15;
    localparam int CH_STRIDE  = 8;
    localparam int CTRL_WORD  = NUM_CH;
    localparam logic [WORD_W-1:0] CTRL_MASK = 32'h00FF_FFF3;

    typedef enum logic [1:0] {
        CH_IDLE = 2'd0,
        CH_HIGH = 2'd1,
        CH_LOW  = 2'd2,
        CH_ZERO = 2'd3
    } ch_state_e;
endpackage

// File: rtl/pwm_pair_regs.sv
module pwm_pair_regs
    import pwm_pair_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                we_i,
    input  logic [ADDR_W-1:0]                   addr_i,
    input  logic [WORD_W-1:0]                   wdata_i,
    output logic [WORD_W-1:0]                   rdata_o,
    output logic [NUM_CH-1:0][WORD_W-1:0]       cnt_o,
    output logic [NUM_CH-1:0]                   en_o,
    output logic [NUM_CH-1:0]                   gate_o,
    output logic [NUM_CH-1:0][SEL_W-1:0]        sel_o,
    output logic [NUM_CH-1:0][DIV_W-1:0]        div_o
);
    localparam int IDX_W = ADDR_W - 2;

    logic [NUM_CH-1:0][WORD_W-1:0] cnt_q;
    logic [WORD_W-1:0]             ctrl_q;
    logic                          aligned;
    logic [IDX_W-1:0]              widx;

    assign aligned = (addr_i[1:0] == 2'b00);
    assign widx    = addr_i[ADDR_W-1:2];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            ctrl_q <= '0;
        end else if (we_i && aligned) begin
            for (int i = 0; i < NUM_CH; i++) begin
                if (widx == IDX_W'(i)) cnt_q[i] <= wdata_i;
            end
            if (widx == IDX_W'(CTRL_WORD)) ctrl_q <= wdata_i & CTRL_MASK;
        end
    end

    always_comb begin
        rdata_o = '0;
        if (aligned) begin
            for (int i = 0; i < NUM_CH; i++) begin
                if (widx == IDX_W'(i)) rdata_o = cnt_q[i];
            end
            if (widx == IDX_W'(CTRL_WORD)) rdata_o = ctrl_q;
        end
    end

    always_comb begin
        for (int i = 0; i < NUM_CH; i++) begin
            en_o[i]   = ctrl_q[EN_LSB + i];
            gate_o[i] = ctrl_q[GATE_LSB + CH_STRIDE*i];
            sel_o[i]  = ctrl_q[SEL_LSB + SEL_STRIDE*i +: SEL_W];
            div_o[i]  = ctrl_q[DIV_LSB + CH_STRIDE*i +: DIV_W];
        end
    end

    assign cnt_o = cnt_q;

    // R2: registers change only on a write strobe
    assert_ctrl_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !we_i |=> $stable(ctrl_q));
    assert_cnt_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !we_i |=> $stable(cnt_q));
endmodule

// File: rtl/pwm_pair_prescale.sv
module pwm_pair_prescale
    import pwm_pair_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             src_tick_i,
    input  logic             run_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             ptick_o
);
    logic [DIV_W-1:0] cnt_q;
    logic             wrap;

    assign wrap    = (cnt_q >= div_i);
    assign ptick_o = run_i && src_tick_i && wrap;

    always_ff @(posedge clk) begin
        if (!rst_n || !run_i) begin
            cnt_q <= '0;
        end else if (src_tick_i) begin
            cnt_q <= wrap ? '0 : cnt_q + 1'b1;
        end
    end

    // R4: every prescaled tick restarts the divide count
    assert_wrap_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ptick_o |=> (cnt_q == '0));
    // R6: a closed gate leaves the divider parked
    assert_gate_parked_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> (cnt_q == '0));
endmodule

// File: rtl/pwm_pair_chan.sv
module pwm_pair_chan
    import pwm_pair_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             ptick_i,
    input  logic [CNT_W-1:0] mark_i,
    input  logic [CNT_W-1:0] space_i,
    output logic             pwm_o
);
    ch_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W-1:0] space_q, space_d;
    logic             restart;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CH_IDLE;
            cnt_q   <= '0;
            space_q <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            space_q <= space_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        space_d = space_q;
        restart = 1'b0;
        if (!en_i) begin
            state_d = CH_IDLE;
            cnt_d   = '0;
            space_d = '0;
        end else begin
            unique case (state_q)
                CH_IDLE: restart = 1'b1;
                CH_ZERO: restart = ptick_i;
                CH_HIGH: begin
                    if (ptick_i) begin
                        if (cnt_q == CNT_W'(1)) begin
                            if (space_q != '0) begin
                                state_d = CH_LOW;
                                cnt_d   = space_q;
                            end else begin
                                restart = 1'b1;
                            end
                        end else begin
                            cnt_d = cnt_q - 1'b1;
                        end
                    end
                end
                CH_LOW: begin
                    if (ptick_i) begin
                        if (cnt_q == CNT_W'(1)) restart = 1'b1;
                        else                    cnt_d = cnt_q - 1'b1;
                    end
                end
            endcase
        end
        if (restart) begin
            space_d = space_i;
            if (mark_i != '0) begin
                state_d = CH_HIGH;
                cnt_d   = mark_i;
            end else if (space_i != '0) begin
                state_d = CH_LOW;
                cnt_d   = space_i;
            end else begin
                state_d = CH_ZERO;
                cnt_d   = '0;
            end
        end
    end

    always_comb begin
        pwm_o = (state_q == CH_HIGH);
    end

    // R10: disable sends the sequencer to IDLE with a low output
    assert_disable_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (state_q == CH_IDLE && !pwm_o));
    // R10: enable with a nonzero mark rises on the next clock
    assert_enable_rise_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_IDLE && en_i && mark_i != '0) |=> pwm_o);
    // R3: a counting phase never holds an exhausted count
    assert_count_live_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_HIGH || state_q == CH_LOW) |-> (cnt_q != '0));
    // R6: without a tick the mark phase is held
    assert_no_tick_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !ptick_i && state_q == CH_HIGH) |=> (state_q == CH_HIGH));
    // R7: zero space with nonzero mark keeps the output high
    assert_const_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && state_q == CH_HIGH && space_q == '0 && space_i == '0 && mark_i != '0)
        |=> pwm_o);
    // R8: both counts zero keep the output low
    assert_zero_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && state_q == CH_ZERO && mark_i == '0 && space_i == '0) |=> !pwm_o);
endmodule

// File: rtl/pwm_pair.sv
module pwm_pair
    import pwm_pair_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_we,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [WORD_W-1:0]  bus_wdata,
    output logic [WORD_W-1:0]  bus_rdata,
    input  logic [NUM_SRC-1:0] tick_src,
    output logic [NUM_CH-1:0]  pwm_o
);
    logic [NUM_CH-1:0][WORD_W-1:0] cnt_w;
    logic [NUM_CH-1:0]             en_w;
    logic [NUM_CH-1:0]             gate_w;
    logic [NUM_CH-1:0][SEL_W-1:0]  sel_w;
    logic [NUM_CH-1:0][DIV_W-1:0]  div_w;

    pwm_pair_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (bus_we),
        .addr_i  (bus_addr),
        .wdata_i (bus_wdata),
        .rdata_o (bus_rdata),
        .cnt_o   (cnt_w),
        .en_o    (en_w),
        .gate_o  (gate_w),
        .sel_o   (sel_w),
        .div_o   (div_w)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        logic ptick;

        pwm_pair_prescale u_pre (
            .clk        (clk),
            .rst_n      (rst_n),
            .src_tick_i (tick_src[sel_w[ch]]),
            .run_i      (gate_w[ch] & en_w[ch]),
            .div_i      (div_w[ch]),
            .ptick_o    (ptick)
        );

        pwm_pair_chan u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .en_i    (en_w[ch]),
            .ptick_i (ptick),
            .mark_i  (cnt_w[ch][MARK_LSB +: CNT_W]),
            .space_i (cnt_w[ch][0 +: CNT_W]),
            .pwm_o   (pwm_o[ch])
        );
    end
endmodule

// File: tb/pwm_pair_bench.sv
module pwm_pair_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  tick_src;
    logic [1:0]  pwm_o;
    logic [1:0]  tcnt = '0;
    int          tests = 0;
    int          fails = 0;

    always #4 clk = ~clk;

    always_ff @(posedge clk) tcnt <= tcnt + 2'd1;
    // src0 every clock, src1 every 2nd, src2 every 4th, src3 never
    assign tick_src = {1'b0, (tcnt == 2'd0), tcnt[0], 1'b1};

    pwm_pair u_pwm_pair (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick_src(tick_src),
        .pwm_o(pwm_o)
    );

    typedef struct packed {
        logic [31:0] ctrl;
        logic [31:0] cnt;
        logic [15:0] exp_hi;
        logic [15:0] exp_lo;
    } vec_t;

    // channel A: R3 counts, R4 prescaler, R5 source select
    localparam vec_t VECS [0:4] = '{
        '{32'h0000_8001, 32'h0003_0005, 16'd3, 16'd5},
        '{32'h0000_8201, 32'h0002_0001, 16'd6, 16'd3},
        '{32'h0000_8011, 32'h0002_0003, 16'd4, 16'd6},
        '{32'h0000_8121, 32'h0001_0002, 16'd8, 16'd16},
        '{32'h0000_8001, 32'h0001_0001, 16'd1, 16'd1}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic bus_read(input string tag, input logic [3:0] a, input logic [31:0] exp);
        @(negedge clk);
        bus_addr = a;
        #1;
        chk(tag, bus_rdata, exp);
    endtask

    task automatic wait_level(input int ch, input logic lvl);
        int n = 0;
        while (pwm_o[ch] !== lvl && n < 3000) begin
            @(negedge clk);
            n++;
        end
        if (n >= 3000) chk("wait timeout", {31'd0, pwm_o[ch]}, {31'd0, lvl});
    endtask

    task automatic run_len(input int ch, input logic lvl, output int n);
        n = 1;
        for (int k = 0; k < 3000; k++) begin
            @(negedge clk);
            if (pwm_o[ch] !== lvl) break;
            n++;
        end
    endtask

    task automatic hold_check(input string tag, input int ch, input logic lvl, input int cycles);
        int bad = 0;
        for (int k = 0; k < cycles; k++) begin
            @(negedge clk);
            if (pwm_o[ch] !== lvl) bad++;
        end
        chk(tag, bad, 0);
    endtask

    task automatic measure(input int ch, output int hi, output int lo);
        wait_level(ch, 1'b1);
        wait_level(ch, 1'b0);
        wait_level(ch, 1'b1);
        run_len(ch, 1'b1, hi);
        run_len(ch, 1'b0, lo);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int hi, lo, n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        bus_read("R1 count A reset", 4'h0, 32'h0);
        bus_read("R1 count B reset", 4'h4, 32'h0);
        bus_read("R1 control reset", 4'h8, 32'h0);
        chk("R1 outputs reset", {30'd0, pwm_o}, 32'h0);

        // R2 register map
        bus_write(4'h8, 32'hFFFF_FFFF);
        bus_read("R2 control mask", 4'h8, 32'h00FF_FFF3);
        bus_write(4'h8, 32'h0);
        bus_write(4'h0, 32'hA5A5_5A5A);
        bus_write(4'h4, 32'h5A5A_A5A5);
        bus_read("R2 count A roundtrip", 4'h0, 32'hA5A5_5A5A);
        bus_read("R2 count B roundtrip", 4'h4, 32'h5A5A_A5A5);
        bus_write(4'hC, 32'h1234_5678);
        bus_read("R2 offset C reads zero", 4'hC, 32'h0);
        bus_write(4'h9, 32'hFFFF_FFFF);
        bus_read("R2 misaligned write ignored", 4'h8, 32'h0);
        bus_read("R2 misaligned read zero", 4'h1, 32'h0);

        // vector table: R3 R4 R5 on channel A
        foreach (VECS[i]) begin
            bus_write(4'h8, 32'h0);
            bus_write(4'h0, VECS[i].cnt);
            bus_write(4'h8, VECS[i].ctrl);
            measure(0, hi, lo);
            chk($sformatf("R3 R4 R5 vec%0d high run", i), hi, {16'd0, VECS[i].exp_hi});
            chk($sformatf("R3 R4 R5 vec%0d low run", i), lo, {16'd0, VECS[i].exp_lo});
        end

        // R10 disabled low, fresh high phase on enable
        bus_write(4'h8, 32'h0);
        bus_write(4'h0, 32'h0003_0003);
        hold_check("R10 disabled stays low", 0, 1'b0, 20);
        bus_write(4'h8, 32'h0000_8001);
        @(negedge clk);
        chk("R10 rises after enable", {31'd0, pwm_o[0]}, 32'd1);
        bus_write(4'h8, 32'h0);
        @(negedge clk);
        chk("R10 low after disable", {31'd0, pwm_o[0]}, 32'd0);
        bus_write(4'h8, 32'h0000_8001);
        @(negedge clk);
        run_len(0, 1'b1, n);
        chk("R10 full mark after re-enable", n, 3);

        // R6 gate clear freezes the level
        bus_write(4'h8, 32'h0);
        bus_write(4'h8, 32'h0000_0001);
        hold_check("R6 gate clear holds high", 0, 1'b1, 100);

        // R5 source 3 never ticks
        bus_write(4'h8, 32'h0);
        bus_write(4'h8, 32'h0000_8031);
        hold_check("R5 idle source holds high", 0, 1'b1, 100);

        // R7 constant levels
        bus_write(4'h8, 32'h0);
        bus_write(4'h0, 32'h0004_0000);
        bus_write(4'h8, 32'h0000_8001);
        @(negedge clk);
        hold_check("R7 zero space constant high", 0, 1'b1, 200);
        bus_write(4'h8, 32'h0);
        bus_write(4'h0, 32'h0000_0004);
        bus_write(4'h8, 32'h0000_8001);
        hold_check("R7 zero mark constant low", 0, 1'b0, 200);

        // R8 both zero
        bus_write(4'h8, 32'h0);
        bus_write(4'h0, 32'h0);
        bus_write(4'h8, 32'h0000_8001);
        hold_check("R8 both zero low", 0, 1'b0, 100);

        // R9 reload at the period boundary
        bus_write(4'h8, 32'h0);
        bus_write(4'h0, 32'h0004_0004);
        bus_write(4'h8, 32'h0000_8001);
        wait_level(0, 1'b1);
        wait_level(0, 1'b0);
        wait_level(0, 1'b1);
        bus_write(4'h0, 32'h0002_0002);
        run_len(0, 1'b1, n);
        chk("R9 running mark keeps old count", n + 2, 4);
        run_len(0, 1'b0, n);
        chk("R9 running space keeps old count", n, 4);
        run_len(0, 1'b1, n);
        chk("R9 next mark uses new count", n, 2);

        // R11 channel B alone
        bus_write(4'h8, 32'h0);
        bus_write(4'h4, 32'h0002_0002);
        bus_write(4'h8, 32'h0081_0002);
        measure(1, hi, lo);
        chk("R11 channel B high run", hi, 4);
        chk("R11 channel B low run", lo, 4);
        hold_check("R11 channel A stays low", 0, 1'b0, 20);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule